// File: doc/BRIEF.md
# Secure-Aware Interrupt Enable Register

This block holds the interrupt enable bits for a bank of external interrupt lines and one security-check interrupt. Software reaches the enables through two register aliases. One alias only clears bits and the other only sets them, so no read-modify-write is needed. Both aliases read back the same enable image. Several bus ports share the block, and each port carries its own security attribute per access.

When mixed-security operation is selected, a non-secure access only sees and changes the enables of lines that a per-line mask marks as non-secure. A write-protect input freezes the enables against every port. The block ANDs per-line pending flags with the enables and drives one registered interrupt request.

Top module: `sec_irq_enable_reg`

## Requirements
- R1: Synchronous active-low reset clears every enable bit and drives `irq_o` low, so both aliases read 0x00000000 after reset.
- R2: A write to the clear alias (byte offset 0x0C) clears each enable whose data bit is 1. Data bits of 0 leave their enables unchanged.
- R3: A write to the set alias (byte offset 0x10) sets each enable whose data bit is 1. Data bits of 0 leave their enables unchanged.
- R4: Reads of either alias return the same enable image. Any other offset reads 0, and writes to it change no enable.
- R5: Bits 15..0 enable lines 15..0 (1 = enabled), and bit 31 is the security-check interrupt enable. Bits 30..16 always read 0 and ignore writes.
- R6: With `mixed_sec_i` high, a non-secure access (`bus_ns_i` bit = 1) reads and writes only the bits 15..0 whose `ns_mask_i` bit is 1. It reads 0 in every other position, including bit 31, and its writes there are dropped without error. Secure accesses, and all accesses with `mixed_sec_i` low, reach every implemented bit.
- R7: While `wprot_i` is high, writes from every port are ignored. Reads still return the enable image.
- R8: When two ports write in the same cycle, a bit that one port clears and the other sets ends up cleared. Bits named by only one of the writes take that write's effect.
- R9: `irq_o` equals the OR over all bits of (pending AND enable), registered one cycle. The pending flag for bit 31 is `top_pend_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | NUM_PORTS (2) | Per-port write strobe |
| bus_ns_i | input | NUM_PORTS (2) | Per-port non-secure attribute of the access |
| bus_addr_i | input | NUM_PORTS x ADDR_W (2x8) | Per-port byte offset |
| bus_wdata_i | input | NUM_PORTS x 32 | Per-port write data |
| bus_rdata_o | output | NUM_PORTS x 32 | Per-port read data (combinational from offset) |
| mixed_sec_i | input | 1 | Mixed-security operation select |
| ns_mask_i | input | NUM_LINES (16) | 1 = line is non-secure |
| wprot_i | input | 1 | Write protection, blocks all writes |
| pend_i | input | NUM_LINES (16) | Per-line pending flags |
| top_pend_i | input | 1 | Pending flag paired with enable bit 31 |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Two events can land in the same clock edge here. The first is a set from one port and a clear from another. The bench provokes it by writing both aliases on the two ports in one cycle with overlapping and disjoint patterns, then compares the readback with (old | set) & ~clear. The second is a pending flag rising on the same edge that its enable is cleared. The bench expects `irq_o` to be high for exactly the one cycle that reflects the old enable, and low from the next cycle on.

// File: rtl/sier_pkg.sv
// Package: shared constants and helpers for the interrupt enable register.
// Assumes a 32-bit register image with at most 31 line enables in the low bits.
package sier_pkg;

    localparam int REG_W   = 32;
    localparam int TOP_BIT = 31;

    // Builds the mask of implemented bits: low lines plus the top bit.
    function automatic logic [REG_W-1:0] impl_mask(input int lines);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < lines; i++) begin
            m[i] = 1'b1;
        end
        m[TOP_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sier_port_filter.sv
// Module: sier_port_filter
// Decodes one bus port into set and clear vectors and its read data, filtered
// by the access's security attribute. Assumes offsets are byte addresses and
// that reads have no side effect.
module sier_port_filter #(
    parameter int                NUM_LINES = 16,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CLR_OFS   = 8'h0C,
    parameter logic [ADDR_W-1:0] SET_OFS   = 8'h10,
    parameter bit                HAS_SEC   = 1'b1
) (
    input  logic                      wr_i,
    input  logic                      ns_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [sier_pkg::REG_W-1:0] wdata_i,
    input  logic                      mixed_i,
    input  logic [NUM_LINES-1:0]      ns_mask_i,
    input  logic [sier_pkg::REG_W-1:0] en_img_i,
    output logic [sier_pkg::REG_W-1:0] set_o,
    output logic [sier_pkg::REG_W-1:0] clr_o,
    output logic [sier_pkg::REG_W-1:0] rdata_o
);
    localparam int                     W    = sier_pkg::REG_W;
    localparam logic [W-1:0]           IMPL = sier_pkg::impl_mask(NUM_LINES);

    logic         hit_clr;
    logic         hit_set;
    logic         ns_limited;
    logic [W-1:0] acc_mask;

    // Purpose: decide which alias the offset hits.
    always_comb begin
        hit_clr = (addr_i == CLR_OFS);
        hit_set = (addr_i == SET_OFS);
    end

    // Purpose: compute the bits this access may see and change.
    always_comb begin
        ns_limited = HAS_SEC && mixed_i && ns_i;
        if (ns_limited) begin
            acc_mask = W'(ns_mask_i) & IMPL;
        end else begin
            acc_mask = IMPL;
        end
    end

    // Purpose: form the filtered write vectors for the enable core.
    always_comb begin
        set_o = (wr_i && hit_set) ? (wdata_i & acc_mask) : '0;
        clr_o = (wr_i && hit_clr) ? (wdata_i & acc_mask) : '0;
    end

    // Purpose: return the shared enable image through either alias.
    always_comb begin
        rdata_o = (hit_clr || hit_set) ? (en_img_i & acc_mask) : '0;
    end

endmodule

// File: rtl/sier_enable_core.sv
// Module: sier_enable_core
// Holds the enable bits. Clear beats set, and write protection freezes the
// state. Only implemented bits get a flop. Assumes the set and clear inputs
// are already merged across ports.
module sier_enable_core #(
    parameter int NUM_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wprot_i,
    input  logic [sier_pkg::REG_W-1:0] set_i,
    input  logic [sier_pkg::REG_W-1:0] clr_i,
    output logic [sier_pkg::REG_W-1:0] en_o
);
    localparam int           W    = sier_pkg::REG_W;
    localparam logic [W-1:0] IMPL = sier_pkg::impl_mask(NUM_LINES);

    logic [W-1:0] en_d;

    // Purpose: next enable image, with clear winning over set.
    always_comb begin
        en_d = ((en_o | set_i) & ~clr_i) & IMPL;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_ff
            // Purpose: store one implemented enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_o[i] <= 1'b0;
                end else if (!wprot_i) begin
                    en_o[i] <= en_d[i];
                end
            end
        end else begin : g_tie
            assign en_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/sier_irq_merge.sv
// Module: sier_irq_merge
// ANDs the pending flags with the enables and registers the OR of the result.
// Assumes the pending flags are synchronous to clk.
module sier_irq_merge #(
    parameter int NUM_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [sier_pkg::REG_W-1:0] en_i,
    input  logic [NUM_LINES-1:0]       pend_i,
    input  logic                       top_pend_i,
    output logic                       irq_o
);
    localparam int W = sier_pkg::REG_W;

    logic [W-1:0] pend_img;

    // Purpose: place the pending flags at their enable positions.
    always_comb begin
        pend_img = W'(pend_i);
        pend_img[sier_pkg::TOP_BIT] = top_pend_i;
    end

    // Purpose: register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= |(pend_img & en_i);
        end
    end

endmodule

// File: rtl/sec_irq_enable_reg.sv
// Module: sec_irq_enable_reg (top)
// Interrupt enable register with set and clear aliases, several bus ports,
// per-line security filtering, write protection and a combined request.
// Assumes every port is synchronous to clk and that offsets are byte addresses.
module sec_irq_enable_reg #(
    parameter int                NUM_LINES = 16,
    parameter int                NUM_PORTS = 2,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CLR_OFS   = 8'h0C,
    parameter logic [ADDR_W-1:0] SET_OFS   = 8'h10,
    parameter bit                HAS_SEC   = 1'b1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0]                  bus_wr_i,
    input  logic [NUM_PORTS-1:0]                  bus_ns_i,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]      bus_addr_i,
    input  logic [NUM_PORTS-1:0][31:0]            bus_wdata_i,
    output logic [NUM_PORTS-1:0][31:0]            bus_rdata_o,
    input  logic                                  mixed_sec_i,
    input  logic [NUM_LINES-1:0]                  ns_mask_i,
    input  logic                                  wprot_i,
    input  logic [NUM_LINES-1:0]                  pend_i,
    input  logic                                  top_pend_i,
    output logic                                  irq_o
);
    localparam int W = sier_pkg::REG_W;

    logic [NUM_PORTS-1:0][W-1:0] set_vec;
    logic [NUM_PORTS-1:0][W-1:0] clr_vec;
    logic [W-1:0]                set_any;
    logic [W-1:0]                clr_any;
    logic [W-1:0]                en_img;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        sier_port_filter #(
            .NUM_LINES (NUM_LINES),
            .ADDR_W    (ADDR_W),
            .CLR_OFS   (CLR_OFS),
            .SET_OFS   (SET_OFS),
            .HAS_SEC   (HAS_SEC)
        ) filt_i (
            .wr_i      (bus_wr_i[p]),
            .ns_i      (bus_ns_i[p]),
            .addr_i    (bus_addr_i[p]),
            .wdata_i   (bus_wdata_i[p]),
            .mixed_i   (mixed_sec_i),
            .ns_mask_i (ns_mask_i),
            .en_img_i  (en_img),
            .set_o     (set_vec[p]),
            .clr_o     (clr_vec[p]),
            .rdata_o   (bus_rdata_o[p])
        );
    end

    // Purpose: merge the write vectors of all ports.
    always_comb begin
        set_any = '0;
        clr_any = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            set_any = set_any | set_vec[p];
            clr_any = clr_any | clr_vec[p];
        end
    end

    sier_enable_core #(
        .NUM_LINES (NUM_LINES)
    ) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wprot_i (wprot_i),
        .set_i   (set_any),
        .clr_i   (clr_any),
        .en_o    (en_img)
    );

    sier_irq_merge #(
        .NUM_LINES (NUM_LINES)
    ) irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_img),
        .pend_i     (pend_i),
        .top_pend_i (top_pend_i),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/sier_chk.sv
// Module: sier_chk
// Assertion checker bound to sec_irq_enable_reg. It observes the merged write
// vectors, the enable image and the ports.
module sier_chk #(
    parameter int NUM_LINES = 16,
    parameter int NUM_PORTS = 2,
    parameter bit HAS_SEC   = 1'b1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wprot_i,
    input logic                       mixed_sec_i,
    input logic [NUM_LINES-1:0]       ns_mask_i,
    input logic [NUM_PORTS-1:0]       bus_ns_i,
    input logic [NUM_PORTS-1:0][31:0] bus_rdata_o,
    input logic [NUM_LINES-1:0]       pend_i,
    input logic                       top_pend_i,
    input logic [31:0]                set_any,
    input logic [31:0]                clr_any,
    input logic [31:0]                en_img,
    input logic                       irq_o
);
    localparam logic [31:0] IMPL = sier_pkg::impl_mask(NUM_LINES);

    logic [31:0] pend_img;
    assign pend_img = {top_pend_i, 31'(pend_i)};

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (en_img == '0 && !irq_o)); // R1

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!wprot_i && clr_any != '0) |=> ((en_img & $past(clr_any)) == '0)); // R8

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!wprot_i && (set_any & ~clr_any) != '0)
        |=> ((en_img & $past(set_any & ~clr_any)) == $past(set_any & ~clr_any))); // R3

    AST_PROTECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        wprot_i |=> $stable(en_img)); // R7

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(en_img & pend_img)))); // R9

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
        AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rdata_o[p] & ~IMPL) == '0); // R5

        AST_NS_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (HAS_SEC && mixed_sec_i && bus_ns_i[p])
            |-> ((bus_rdata_o[p] & ~32'(ns_mask_i)) == '0)); // R6
    end

endmodule

bind sec_irq_enable_reg sier_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_PORTS (NUM_PORTS),
    .HAS_SEC   (HAS_SEC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wprot_i     (wprot_i),
    .mixed_sec_i (mixed_sec_i),
    .ns_mask_i   (ns_mask_i),
    .bus_ns_i    (bus_ns_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_i      (pend_i),
    .top_pend_i  (top_pend_i),
    .set_any     (set_any),
    .clr_any     (clr_any),
    .en_img      (en_img),
    .irq_o       (irq_o)
);

// File: tb/sec_irq_enable_reg_tb_top.sv
`timescale 1ns/1ps
module sec_irq_enable_reg_tb_top;

    localparam logic [31:0] IMPL = 32'h8000_FFFF;
    localparam logic [7:0]  OCLR = 8'h0C;
    localparam logic [7:0]  OSET = 8'h10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        bus_wr = '0;
    logic [1:0]        bus_ns = '0;
    logic [1:0][7:0]   bus_addr = '0;
    logic [1:0][31:0]  bus_wdata = '0;
    logic [1:0][31:0]  bus_rdata;
    logic              mixed = 1'b0;
    logic [15:0]       ns_mask = '0;
    logic              wprot = 1'b0;
    logic [15:0]       pend = '0;
    logic              top_pend = 1'b0;
    logic              irq;

    int          n_chk  = 0;
    int          n_fail = 0;
    logic [31:0] en_m   = '0;

    always #4 clk = ~clk;

    sec_irq_enable_reg dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_ns_i    (bus_ns),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .mixed_sec_i (mixed),
        .ns_mask_i   (ns_mask),
        .wprot_i     (wprot),
        .pend_i      (pend),
        .top_pend_i  (top_pend),
        .irq_o       (irq)
    );

    function automatic logic [31:0] acc_of(input logic ns);
        return (mixed && ns) ? {16'h0, ns_mask} : IMPL;
    endfunction

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Both ports drive in one cycle; the model applies R2/R3/R6/R7/R8 arithmetic.
    task automatic wr2(input logic w0, input logic [7:0] a0, input logic [31:0] d0, input logic n0,
                       input logic w1, input logic [7:0] a1, input logic [31:0] d1, input logic n1);
        logic [31:0] s, c;
        @(negedge clk);
        bus_wr    = {w1, w0};
        bus_addr  = {a1, a0};
        bus_wdata = {d1, d0};
        bus_ns    = {n1, n0};
        s = '0; c = '0;
        if (w0 && a0 == OSET) s |= d0 & acc_of(n0);
        if (w0 && a0 == OCLR) c |= d0 & acc_of(n0);
        if (w1 && a1 == OSET) s |= d1 & acc_of(n1);
        if (w1 && a1 == OCLR) c |= d1 & acc_of(n1);
        @(posedge clk);
        if (!wprot) en_m = ((en_m | s) & ~c) & IMPL;
        #1;
        bus_wr = '0;
    endtask

    task automatic wr1(input logic [7:0] a, input logic [31:0] d, input logic ns);
        wr2(1'b1, a, d, ns, 1'b0, 8'h00, 32'h0, 1'b0);
    endtask

    task automatic rd(input string req, input int p, input logic [7:0] a, input logic ns);
        logic [31:0] exp;
        @(negedge clk);
        bus_addr[p] = a;
        bus_ns[p]   = ns;
        #1;
        exp = (a == OSET || a == OCLR) ? (en_m & acc_of(ns)) : 32'h0;
        check32(req, bus_rdata[p], exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, irq, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] masks [6];
        masks = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0F0F, 16'h8001, 16'h7E3C};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd("R1", 0, OCLR, 1'b0);
        rd("R1", 1, OSET, 1'b0);
        irq_chk("R1", 1'b0);

        // R3/R2/R4/R5: walk every bit position through both aliases
        for (int b = 0; b < 32; b++) begin
            wr1(OSET, 32'h1 << b, 1'b0);
            rd("R3", 0, OSET, 1'b0);
            rd("R4", 1, OCLR, 1'b0);
            wr1(OSET, 32'h0, 1'b0);
            rd("R3", 0, OSET, 1'b0);
            wr1(OCLR, 32'h0, 1'b0);
            rd("R2", 0, OCLR, 1'b0);
            wr1(OCLR, 32'h1 << b, 1'b0);
            rd("R2", 1, OSET, 1'b0);
        end
        wr1(OSET, 32'hFFFF_FFFF, 1'b0);
        check32("R5", en_m, IMPL);
        rd("R5", 0, OSET, 1'b0);
        // R4: other offsets
        wr1(8'h08, 32'hFFFF_FFFF, 1'b0);
        wr1(8'h14, 32'hFFFF_FFFF, 1'b0);
        rd("R4", 0, OSET, 1'b0);
        rd("R4", 1, 8'h08, 1'b0);
        rd("R4", 0, 8'h14, 1'b0);

        // R6: security filtering across mask patterns and attributes
        for (int m = 0; m < 6; m++) begin
            for (int mx = 0; mx < 2; mx++) begin
                @(negedge clk);
                mixed   = mx[0];
                ns_mask = masks[m];
                wr1(OSET, 32'hFFFF_FFFF, 1'b0);
                wr1(OCLR, 32'hFFFF_FFFF, 1'b1);
                rd("R6", 0, OSET, 1'b1);
                rd("R6", 1, OCLR, 1'b0);
                wr1(OSET, 32'h8000_5A5A, 1'b1);
                rd("R6", 1, OSET, 1'b1);
                rd("R6", 0, OCLR, 1'b0);
            end
        end
        @(negedge clk);
        mixed = 1'b0;

        // R7: write protection
        wr1(OSET, 32'h0000_00F0, 1'b0);
        @(negedge clk);
        wprot = 1'b1;
        wr2(1'b1, OCLR, 32'hFFFF_FFFF, 1'b0, 1'b1, OSET, 32'hFFFF_FFFF, 1'b0);
        rd("R7", 0, OSET, 1'b0);
        rd("R7", 1, OCLR, 1'b0);
        @(negedge clk);
        wprot = 1'b0;

        // R8: both ports in one cycle, overlapping and disjoint
        for (int k = 0; k < 8; k++) begin
            logic [31:0] sp, cp;
            sp = 32'h8000_0000 | (32'h1357 << k);
            cp = 32'h8000_0000 | (32'h0F0F >> k);
            wr1(OCLR, 32'hFFFF_FFFF, 1'b0);
            wr1(OSET, 32'h0000_3C3C, 1'b0);
            if (k[0]) wr2(1'b1, OSET, sp, 1'b0, 1'b1, OCLR, cp, 1'b0);
            else      wr2(1'b1, OCLR, cp, 1'b0, 1'b1, OSET, sp, 1'b0);
            rd("R8", 0, OSET, 1'b0);
        end

        // R9: combined request per implemented bit
        for (int b = 0; b < 32; b++) begin
            if (IMPL[b]) begin
                wr1(OCLR, 32'hFFFF_FFFF, 1'b0);
                wr1(OSET, 32'h1 << b, 1'b0);
                @(negedge clk);
                pend = ~16'(32'h1 << b);
                top_pend = (b != 31);
                @(posedge clk); #1;
                irq_chk("R9", 1'b0);
                @(negedge clk);
                pend = 16'(32'h1 << b);
                top_pend = (b == 31);
                @(posedge clk); #1;
                irq_chk("R9", 1'b1);
                @(negedge clk);
                pend = '0; top_pend = 1'b0;
                @(posedge clk); #1;
                irq_chk("R9", 1'b0);
            end
        end

        // R9/R2: pending rises on the edge that clears its enable
        wr1(OSET, 32'h0000_0004, 1'b0);
        @(negedge clk);
        pend = 16'h0004;
        bus_wr[0] = 1'b1; bus_addr[0] = OCLR; bus_wdata[0] = 32'h4; bus_ns[0] = 1'b0;
        @(posedge clk); #1;
        bus_wr = '0;
        en_m = en_m & ~32'h4;
        irq_chk("R9", 1'b1);
        @(posedge clk); #1;
        irq_chk("R9", 1'b0);
        rd("R2", 0, OSET, 1'b0);
        @(negedge clk);
        pend = '0;

        // R1: reset again clears enables
        wr1(OSET, 32'hFFFF_FFFF, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        en_m = '0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1", 0, OSET, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule